// File: doc/BRIEF.md
# Microsequencer Debug Breakpoint Controller

This block sits beside a small microcoded timer engine and stops it when a debug condition that software has armed comes true. It compares the engine's microprogram counter and channel register against two breakpoint registers. It also samples the engine's host-service, link-service, match-recognition and transition-detect latches. When an armed condition hits, it raises a halt request and a breakpoint-asserted line toward the system bus. It also records which kind of condition caused the stop, in sticky flags.

The breakpoint state is released by a breakpoint-acknowledge pulse or by the global freeze input. Separately, a two-bit freeze-response field selects the point at which the engine honours a global freeze: never, at the end of the current microcycle, or at the next time-slot boundary. A channel-latch control bit selects what a microcode write to the channel register captures. Either only the new channel's pin state is captured, or its pin state and both condition latches are captured; the block reports this as two capture strobes.

Configuration is loaded through a plain write port with a two-bit register select. All control and status pins are level or single-cycle pulse signals. There is no streaming data path, so no valid/ready handshake and no back-pressure.

Top module: `mseq_brk_ctrl`

## Requirements
- R1: After reset, all configuration and status state is zero: `halt_o`, `bkpt_o`, `stat_o`, `frz_req_o`, `cap_pin_o` and `cap_cond_o` are low, and no break can occur until a condition is enabled.
- R2: A write with `cfg_we` high loads the addressed register at the clock edge. Select 0 is control: bits [5:0] are enables (bit 0 PC, bit 1 channel, bit 2 host service, bit 3 link service, bit 4 match latch, bit 5 transition latch), bits [7:6] are the freeze mode and bit 8 is the channel-latch control. Select 1 is the PC breakpoint and select 2 is the channel breakpoint. A write to select 3 changes nothing.
- R3: With the PC enable set, `upc_i` equal to the PC breakpoint in any cycle sets BKPT and PCBK at the next edge. A mismatch sets nothing.
- R4: With the channel enable set, `chan_i` equal to the channel breakpoint sets BKPT and CHBK at the next edge, but only in a cycle where `state_start_i` or `chan_wr_i` is high.
- R5: The host-service and link-service conditions set BKPT and SRBK, and the match and transition latch conditions set BKPT alone. All four are sampled only in a cycle with `state_start_i` high.
- R6: A condition whose enable bit is clear has no effect, whatever its inputs.
- R7: When several enabled conditions hit in one cycle, every matching cause flag is set together with a single BKPT.
- R8: BKPT and the cause flags are sticky. They are cleared together at the edge after `bkpt_ack_i` or `freeze_i` is high, and the clear wins over a hit in the same cycle.
- R9: `halt_o` and `bkpt_o` both equal BKPT. `stat_o` is {SRBK, CHBK, PCBK, BKPT}, from bit 3 down to bit 0.
- R10: Freeze mode 00 or 11 never raises `frz_req_o`. Mode 01 raises it at the edge after a cycle with `freeze_i` and `ucycle_end_i` both high. Mode 10 does the same with `slot_bound_i`. Once raised, it stays high while `freeze_i` stays high and drops at the edge after `freeze_i` falls.
- R11: A cycle with `chan_wr_i` high pulses `cap_pin_o` at the next edge. `cap_cond_o` pulses with it only when the channel-latch control is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select: 0 control, 1 PC breakpoint, 2 channel breakpoint, 3 none |
| cfg_wdata | input | CFG_W (16) | Configuration write data |
| upc_i | input | PC_W (9) | Current microprogram counter |
| chan_i | input | CH_W (4) | Channel register value; the newly written value when `chan_wr_i` is high |
| chan_wr_i | input | 1 | Microcode write to the channel register |
| state_start_i | input | 1 | First cycle of a state |
| hsl_i | input | 1 | Host-service latch |
| lsl_i | input | 1 | Link-service latch |
| mrl_i | input | 1 | Match-recognition latch |
| tdl_i | input | 1 | Transition-detect latch |
| ucycle_end_i | input | 1 | End of the current microcycle |
| slot_bound_i | input | 1 | Time-slot boundary |
| freeze_i | input | 1 | Global freeze |
| bkpt_ack_i | input | 1 | Breakpoint acknowledge cycle seen |
| halt_o | output | 1 | Halt request to the engine |
| bkpt_o | output | 1 | Breakpoint asserted on the bus |
| stat_o | output | 4 | {SRBK, CHBK, PCBK, BKPT} |
| frz_req_o | output | 1 | Engine freeze request |
| cap_pin_o | output | 1 | Capture the new channel's pin state |
| cap_cond_o | output | 1 | Also capture the new channel's match and transition latches |

## Verification
Every result is one register stage away from its cause. A configuration write, a breakpoint hit, a clear, a freeze condition and a channel write each show up at the outputs at the first clock edge after the cycle that presents them. The bench drives inputs on the falling edge, lets one rising edge capture them, and samples on the following falling edge. It returns the stimulus inputs to idle before that sample, so a sticky flag seen there cannot have been set by a lingering input. Clear-priority and hold-over cases are checked across several such cycles, one edge at a time.

// File: rtl/mseq_brk_pkg.sv
package mseq_brk_pkg;
  localparam int NCOND  = 6;
  localparam int FRZ_LO = NCOND;
  localparam int LATCH_BIT = NCOND + 2;
  localparam int CTRL_W = NCOND + 3;

  localparam int EN_PC  = 0;
  localparam int EN_CH  = 1;
  localparam int EN_HSL = 2;
  localparam int EN_LSL = 3;
  localparam int EN_MRL = 4;
  localparam int EN_TDL = 5;

  typedef enum logic [1:0] {
    FRZ_NONE = 2'b00,
    FRZ_UCYC = 2'b01,
    FRZ_SLOT = 2'b10,
    FRZ_RSVD = 2'b11
  } frz_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_PCBP  = 2'd1,
    SEL_CHBP  = 2'd2,
    SEL_SPARE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/mseq_brk_regs.sv
module mseq_brk_regs
  import mseq_brk_pkg::*;
#(
  parameter int PC_W  = 9,
  parameter int CH_W  = 4,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [CFG_W-1:0] wdata,
  output logic [NCOND-1:0] en,
  output frz_mode_e        frz_mode,
  output logic             latch_all,
  output logic [PC_W-1:0]  pc_bp,
  output logic [CH_W-1:0]  ch_bp
);
  logic [CTRL_W-1:0] ctrl_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pc_bp  <= '0;
      ch_bp  <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_CTRL: ctrl_q <= wdata[CTRL_W-1:0];
        SEL_PCBP: pc_bp  <= wdata[PC_W-1:0];
        SEL_CHBP: ch_bp  <= wdata[CH_W-1:0];
        default:  ;
      endcase
    end
  end

  assign en        = ctrl_q[NCOND-1:0];
  assign frz_mode  = frz_mode_e'(ctrl_q[FRZ_LO+1:FRZ_LO]);
  assign latch_all = ctrl_q[LATCH_BIT];
endmodule

// File: rtl/mseq_brk_cond.sv
module mseq_brk_cond
  import mseq_brk_pkg::*;
#(
  parameter int PC_W = 9,
  parameter int CH_W = 4
) (
  input  logic [NCOND-1:0] en,
  input  logic [PC_W-1:0]  pc_bp,
  input  logic [CH_W-1:0]  ch_bp,
  input  logic [PC_W-1:0]  upc,
  input  logic [CH_W-1:0]  chan,
  input  logic             chan_wr,
  input  logic             state_start,
  input  logic             hsl,
  input  logic             lsl,
  input  logic             mrl,
  input  logic             tdl,
  output logic             hit_pc,
  output logic             hit_ch,
  output logic             hit_sr,
  output logic             hit_any
);
  localparam int NLATCH = NCOND - EN_HSL;

  logic [NCOND-1:0]  hit;
  logic [NLATCH-1:0] latch_in;

  assign latch_in = {tdl, mrl, lsl, hsl};

  assign hit[EN_PC] = en[EN_PC] && (upc == pc_bp);
  assign hit[EN_CH] = en[EN_CH] && (chan == ch_bp) && (state_start || chan_wr);

  for (genvar g = 0; g < NLATCH; g++) begin : g_latch
    assign hit[EN_HSL + g] = en[EN_HSL + g] && latch_in[g] && state_start;
  end

  assign hit_pc  = hit[EN_PC];
  assign hit_ch  = hit[EN_CH];
  assign hit_sr  = hit[EN_HSL] || hit[EN_LSL];
  assign hit_any = |hit;
endmodule

// File: rtl/mseq_brk_status.sv
module mseq_brk_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_pc,
  input  logic       hit_ch,
  input  logic       hit_sr,
  input  logic       hit_any,
  input  logic       clr,
  output logic [3:0] stat
);
  logic bkpt_q, pcbk_q, chbk_q, srbk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bkpt_q <= 1'b0;
      pcbk_q <= 1'b0;
      chbk_q <= 1'b0;
      srbk_q <= 1'b0;
    end else begin
      bkpt_q <= bkpt_q || hit_any;
      pcbk_q <= pcbk_q || hit_pc;
      chbk_q <= chbk_q || hit_ch;
      srbk_q <= srbk_q || hit_sr;
    end
  end

  assign stat = {srbk_q, chbk_q, pcbk_q, bkpt_q};

  assert_bkpt_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_any && !clr) |=> bkpt_q);
  assert_cause_needs_bkpt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pcbk_q || chbk_q || srbk_q) |-> bkpt_q);
  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stat == 4'b0000));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_q && !clr) |=> bkpt_q);
endmodule

// File: rtl/mseq_brk_freeze.sv
module mseq_brk_freeze
  import mseq_brk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  frz_mode_e mode,
  input  logic      freeze,
  input  logic      ucycle_end,
  input  logic      slot_bound,
  input  logic      latch_all,
  input  logic      chan_wr,
  output logic      frz_req,
  output logic      cap_pin,
  output logic      cap_cond
);
  logic point_hit;

  always_comb begin
    case (mode)
      FRZ_UCYC: point_hit = ucycle_end;
      FRZ_SLOT: point_hit = slot_bound;
      default:  point_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz_req  <= 1'b0;
      cap_pin  <= 1'b0;
      cap_cond <= 1'b0;
    end else begin
      frz_req  <= freeze && (frz_req || point_hit);
      cap_pin  <= chan_wr;
      cap_cond <= chan_wr && latch_all;
    end
  end

  assert_frz_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> !frz_req);
  assert_cond_with_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_cond |-> cap_pin);
endmodule

// File: rtl/mseq_brk_ctrl.sv
module mseq_brk_ctrl
  import mseq_brk_pkg::*;
#(
  parameter int PC_W  = 9,
  parameter int CH_W  = 4,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [PC_W-1:0]  upc_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             chan_wr_i,
  input  logic             state_start_i,
  input  logic             hsl_i,
  input  logic             lsl_i,
  input  logic             mrl_i,
  input  logic             tdl_i,
  input  logic             ucycle_end_i,
  input  logic             slot_bound_i,
  input  logic             freeze_i,
  input  logic             bkpt_ack_i,
  output logic             halt_o,
  output logic             bkpt_o,
  output logic [3:0]       stat_o,
  output logic             frz_req_o,
  output logic             cap_pin_o,
  output logic             cap_cond_o
);
  logic [NCOND-1:0] en;
  frz_mode_e        frz_mode;
  logic             latch_all;
  logic [PC_W-1:0]  pc_bp;
  logic [CH_W-1:0]  ch_bp;
  logic             hit_pc, hit_ch, hit_sr, hit_any;

  mseq_brk_regs #(.PC_W(PC_W), .CH_W(CH_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .en(en), .frz_mode(frz_mode), .latch_all(latch_all),
    .pc_bp(pc_bp), .ch_bp(ch_bp)
  );

  mseq_brk_cond #(.PC_W(PC_W), .CH_W(CH_W)) u_cond (
    .en(en), .pc_bp(pc_bp), .ch_bp(ch_bp), .upc(upc_i), .chan(chan_i),
    .chan_wr(chan_wr_i), .state_start(state_start_i),
    .hsl(hsl_i), .lsl(lsl_i), .mrl(mrl_i), .tdl(tdl_i),
    .hit_pc(hit_pc), .hit_ch(hit_ch), .hit_sr(hit_sr), .hit_any(hit_any)
  );

  mseq_brk_status u_status (
    .clk(clk), .rst_n(rst_n), .hit_pc(hit_pc), .hit_ch(hit_ch),
    .hit_sr(hit_sr), .hit_any(hit_any), .clr(bkpt_ack_i || freeze_i),
    .stat(stat_o)
  );

  mseq_brk_freeze u_freeze (
    .clk(clk), .rst_n(rst_n), .mode(frz_mode), .freeze(freeze_i),
    .ucycle_end(ucycle_end_i), .slot_bound(slot_bound_i),
    .latch_all(latch_all), .chan_wr(chan_wr_i),
    .frz_req(frz_req_o), .cap_pin(cap_pin_o), .cap_cond(cap_cond_o)
  );

  assign halt_o = stat_o[0];
  assign bkpt_o = stat_o[0];

  assert_halt_bkpt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o == bkpt_o);
  assert_no_hit_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0 && stat_o == 4'b0000 && !cfg_we) |=> (stat_o == 4'b0000));
endmodule

// File: tb/mseq_brk_ctrl_test.sv
`timescale 1ns/1ps
module mseq_brk_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic [8:0] upc = '0;
  logic [3:0] chan = '0;
  logic chan_wr = 0, ss = 0, hsl = 0, lsl = 0, mrl = 0, tdl = 0;
  logic ucyc = 0, slot = 0, frz = 0, ack = 0;
  logic halt, bkpt, frz_req, cap_pin, cap_cond;
  logic [3:0] stat;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [8:0] PCBP = 9'h1A5;
  localparam logic [3:0] CHBP = 4'h6;

  // fields: en[28:23] upc[22:14] chan[13:10] ss cw hsl lsl mrl tdl [9:4] exp stat[3:0]
  localparam int NV = 14;
  localparam logic [28:0] VEC [NV] = '{
    {6'b000001, 9'h1A5, 4'h0, 6'b000000, 4'b0011},  // R3 match
    {6'b000001, 9'h1A4, 4'h0, 6'b000000, 4'b0000},  // R3 mismatch
    {6'b000010, 9'h000, 4'h6, 6'b100000, 4'b0101},  // R4 state start
    {6'b000010, 9'h000, 4'h6, 6'b000000, 4'b0000},  // R4 no strobe
    {6'b000010, 9'h000, 4'h6, 6'b010000, 4'b0101},  // R4 channel write
    {6'b000100, 9'h000, 4'h0, 6'b101000, 4'b1001},  // R5 host service
    {6'b000100, 9'h000, 4'h0, 6'b001000, 4'b0000},  // R5 no state start
    {6'b001000, 9'h000, 4'h0, 6'b100100, 4'b1001},  // R5 link service
    {6'b010000, 9'h000, 4'h0, 6'b100010, 4'b0001},  // R5 match latch
    {6'b100000, 9'h000, 4'h0, 6'b100001, 4'b0001},  // R5 transition latch
    {6'b000000, 9'h1A5, 4'h6, 6'b111111, 4'b0000},  // R6 nothing armed
    {6'b111111, 9'h1A5, 4'h6, 6'b101111, 4'b1111},  // R7 all causes
    {6'b111110, 9'h1A5, 4'h6, 6'b101000, 4'b1101},  // R6/R7 PC off
    {6'b100001, 9'h1A5, 4'h0, 6'b000001, 4'b0011}   // R5/R3 latch w/o start
  };

  mseq_brk_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .upc_i(upc), .chan_i(chan), .chan_wr_i(chan_wr),
    .state_start_i(ss), .hsl_i(hsl), .lsl_i(lsl), .mrl_i(mrl), .tdl_i(tdl),
    .ucycle_end_i(ucyc), .slot_bound_i(slot), .freeze_i(frz),
    .bkpt_ack_i(ack), .halt_o(halt), .bkpt_o(bkpt), .stat_o(stat),
    .frz_req_o(frz_req), .cap_pin_o(cap_pin), .cap_cond_o(cap_cond)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    upc = '0; chan = '0; chan_wr = 0; ss = 0; hsl = 0; lsl = 0;
    mrl = 0; tdl = 0; ucyc = 0; slot = 0; frz = 0; ack = 0; cfg_we = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic do_ack();
    ack = 1;
    tick();
    ack = 0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle();
    tick(); tick();
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1 stat", {4'b0, stat}, 8'h00);
    check("R1 outputs", {3'b0, halt, bkpt, frz_req, cap_pin, cap_cond}, 8'h00);
    upc = PCBP; chan = 4'h0; ss = 1; hsl = 1; tdl = 1;
    tick();
    idle();
    check("R1 unarmed", {4'b0, stat}, 8'h00);

    wr(2'd1, {7'b0, PCBP});
    wr(2'd2, {12'b0, CHBP});

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {10'b0, VEC[i][28:23]});
      upc = VEC[i][22:14]; chan = VEC[i][13:10];
      {ss, chan_wr, hsl, lsl, mrl, tdl} = VEC[i][9:4];
      tick();
      idle();
      check($sformatf("R3-R7 vec%0d stat", i), {4'b0, stat}, {4'b0, VEC[i][3:0]});
      check($sformatf("R9 vec%0d halt", i), {6'b0, halt, bkpt},
            {6'b0, VEC[i][0], VEC[i][0]});
      do_ack();
      check($sformatf("R8 vec%0d ack", i), {4'b0, stat}, 8'h00);
    end

    // R8 sticky hold, then ack
    wr(2'd0, 16'h0001);
    upc = PCBP; tick(); idle();
    for (int k = 0; k < 5; k++) tick();
    check("R8 sticky", {4'b0, stat}, 8'h03);
    do_ack();
    check("R8 ack clears", {4'b0, stat}, 8'h00);
    // R8 clear wins over a hit in the same cycle
    upc = PCBP; ack = 1; tick(); idle();
    check("R8 clear priority", {4'b0, stat}, 8'h00);
    // R8 freeze clears
    upc = PCBP; tick(); idle();
    check("R8 set before freeze", {4'b0, stat}, 8'h03);
    frz = 1; tick(); idle();
    check("R8 freeze clears", {4'b0, stat}, 8'h00);

    // R2 select 3 changes nothing: PC break still armed at same address
    wr(2'd3, 16'h01FF);
    upc = PCBP; tick(); idle();
    check("R2 spare select", {4'b0, stat}, 8'h03);
    do_ack();

    // R10 mode 01
    wr(2'd0, 16'h0040);
    frz = 1; tick();
    check("R10 ucyc waits", {7'b0, frz_req}, 8'h00);
    ucyc = 1; tick(); ucyc = 0;
    check("R10 ucyc raise", {7'b0, frz_req}, 8'h01);
    tick();
    check("R10 ucyc hold", {7'b0, frz_req}, 8'h01);
    frz = 0; tick();
    check("R10 drop", {7'b0, frz_req}, 8'h00);
    // R10 mode 10
    wr(2'd0, 16'h0080);
    frz = 1; ucyc = 1; tick(); ucyc = 0;
    check("R10 slot ignores ucyc", {7'b0, frz_req}, 8'h00);
    slot = 1; tick(); slot = 0;
    check("R10 slot raise", {7'b0, frz_req}, 8'h01);
    frz = 0; tick();
    // R10 modes 11 and 00
    wr(2'd0, 16'h00C0);
    frz = 1; ucyc = 1; slot = 1; tick(); tick();
    check("R10 reserved", {7'b0, frz_req}, 8'h00);
    idle();
    wr(2'd0, 16'h0000);
    frz = 1; ucyc = 1; slot = 1; tick();
    check("R10 none", {7'b0, frz_req}, 8'h00);
    idle();

    // R11 channel latch strobes
    tick();
    chan_wr = 1; tick(); chan_wr = 0;
    check("R11 pin only", {6'b0, cap_pin, cap_cond}, 8'h02);
    wr(2'd0, 16'h0100);
    check("R11 idle", {6'b0, cap_pin, cap_cond}, 8'h00);
    chan_wr = 1; tick(); chan_wr = 0;
    check("R11 pin and cond", {6'b0, cap_pin, cap_cond}, 8'h03);
    tick();
    check("R11 one pulse", {6'b0, cap_pin, cap_cond}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule